// File: doc/BRIEF.md
# Strobed Parallel Register Access Bridge

This block is the slave side of an asynchronous parallel host port. An external host reaches a small bank of internal control and status registers through it. The host bus carries an active-low select, a strobe, a direction line, a 12-bit address and a 16-bit data path. The path is split here into an input half, an output half and an output enable, so that a pad ring can build the shared bidirectional bus from them. The select, the strobe and the direction line each pass through a two-flop synchronizer. An access is acted on at the rising edge of the synchronized strobe.

For a write, that one strobe edge takes the address and the data together, and the target register is updated one internal cycle later. For a read, the strobe edge first latches the address. On the following internal cycle the register contents are registered and driven out. A read therefore costs two internal cycles where a write costs one.

Register 0x000 is the host-setup register, and its bit 0 enables address auto-increment. With auto-increment on, only the first strobe after the select falls uses the address on the bus. Each later strobe in the same select window uses the previous address plus one, wrapping modulo 4096. Addresses 0x001 to 0x008 hold eight general 16-bit registers. Every other address is unmapped. The host bus has no back-pressure: the host paces each access through its strobe timing, so there is no valid/ready handshake at this edge.

Top module: `pa_host_bridge`

## Requirements
- R1: While the host select is high (inactive), a strobe changes no register, and the data output enable stays low.
- R2: With the select low and the direction line low, a rising strobe writes the 16-bit data on the input bus into the register at the 12-bit address.
- R3: With the select low and the direction line high, a rising strobe latches the address, and one internal cycle later the register contents appear on the output bus.
- R4: The output enable is high only while the synchronized select is low, the synchronized direction line is high (read) and read data is valid. It is never high during a write.
- R5: The direction line is sampled with the strobe: 1 selects a read, 0 selects a write.
- R6: The host-setup register sits at address 0x000. Bit 0 enables auto-increment, and bits 15:1 read as zero. It resets to 0.
- R7: With auto-increment enabled, the first strobe after the select falls uses the bus address. Each later strobe in that window, whether a read or a write, uses the previous address plus one.
- R8: The incremented address wraps from 0xFFF to 0x000.
- R9: A read of an unmapped address (0x009 to 0xFFF) returns zero. A write to an unmapped address has no effect.
- R10: With auto-increment disabled, every strobe uses the address on the bus.
- R11: The general registers at 0x001 to 0x008 reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host select, active low, asynchronous |
| host_strobe | input | 1 | Address/data strobe, acted on at its synchronized rising edge |
| host_rd_wr | input | 1 | Direction line: 1 read, 0 write |
| host_addr | input | 12 | Register address from host |
| host_data_in | input | 16 | Write data from host (input half of shared bus) |
| host_data_out | output | 16 | Read data to host (output half of shared bus) |
| host_data_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The assertions assume the host holds the select and the direction line steady for at least three internal clocks around every strobe edge. They also assume the host keeps the address and the write data stable while the strobe is high, so the synchronized controls line up with the values on the bus. The stimulus sets the address, data and direction two clocks before it raises the strobe, holds the strobe high for six clocks, and then leaves three idle clocks. It changes the select only when no strobe is in flight, with gaps of at least three clocks on either side.

// File: rtl/pa_host_pkg.sv
package pa_host_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] SETUP_ADDR = '0;
  localparam int AUTOINC_BIT = 0;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/pa_regbank.sv
module pa_regbank
  import pa_host_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              autoinc_en
);
  localparam int FIRST_GEN = 1;
  localparam int LAST_GEN  = FIRST_GEN + NUM_REGS - 1;

  logic setup_q;
  logic [DATA_W-1:0] gen_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) setup_q <= 1'b0;
    else if (wr_en && wr_addr == SETUP_ADDR) setup_q <= wr_data[AUTOINC_BIT];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gen_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(FIRST_GEN + i)) gen_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == SETUP_ADDR) begin
      rd_data[AUTOINC_BIT] = setup_q;
    end else if (int'(rd_addr) >= FIRST_GEN && int'(rd_addr) <= LAST_GEN) begin
      rd_data = gen_q[int'(rd_addr) - FIRST_GEN];
    end
  end

  assign autoinc_en = setup_q;
endmodule

// File: rtl/pa_access_ctrl.sv
module pa_access_ctrl
  import pa_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              strobe_s,
  input  logic              rw_s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              autoinc_en,
  input  logic [DATA_W-1:0] rb_rdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_evt,
  output logic              rd_pend,
  output logic              rd_valid,
  output logic              first_acc,
  output logic [ADDR_W-1:0] last_addr
);
  logic strobe_d;
  logic [ADDR_W-1:0] eff_addr;

  assign acc_evt  = strobe_s && !strobe_d && !cs_s;
  assign eff_addr = (autoinc_en && !first_acc) ? last_addr + ADDR_W'(1) : bus_addr;

  assign wr_en   = acc_evt && !rw_s;
  assign wr_addr = eff_addr;
  assign wr_data = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d  <= 1'b0;
      first_acc <= 1'b1;
      last_addr <= '0;
      rd_addr   <= '0;
      rd_pend   <= 1'b0;
      rd_valid  <= 1'b0;
      rdata     <= '0;
    end else begin
      strobe_d <= strobe_s;
      rd_pend  <= acc_evt && rw_s;
      if (cs_s) begin
        first_acc <= 1'b1;
        rd_valid  <= 1'b0;
      end else if (acc_evt) begin
        first_acc <= 1'b0;
        last_addr <= eff_addr;
        rd_valid  <= 1'b0;
        if (rw_s) rd_addr <= eff_addr;
      end else if (rd_pend) begin
        rdata    <= rb_rdata;
        rd_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pa_host_bridge.sv
module pa_host_bridge
  import pa_host_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_strobe,
  input  logic              host_rd_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data_in,
  output logic [DATA_W-1:0] host_data_out,
  output logic              host_data_oe
);
  logic [2:0] ctl_sync;
  logic cs_s, strobe_s, rw_s;
  logic wr_en, acc_evt, rd_pend, rd_valid, first_acc, autoinc_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr, last_addr;
  logic [DATA_W-1:0] wr_data, rb_rdata, rdata;

  pa_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_cs_n, host_strobe, host_rd_wr}),
    .q(ctl_sync)
  );
  assign cs_s     = ctl_sync[2];
  assign strobe_s = ctl_sync[1];
  assign rw_s     = ctl_sync[0];

  pa_access_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .strobe_s(strobe_s), .rw_s(rw_s),
    .bus_addr(host_addr), .bus_wdata(host_data_in),
    .autoinc_en(autoinc_en), .rb_rdata(rb_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rdata(rdata),
    .acc_evt(acc_evt), .rd_pend(rd_pend), .rd_valid(rd_valid),
    .first_acc(first_acc), .last_addr(last_addr)
  );

  pa_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rb_rdata),
    .autoinc_en(autoinc_en)
  );

  assign host_data_out = rdata;
  assign host_data_oe  = !cs_s && rw_s && rd_valid;
endmodule

// File: rtl/pa_host_bridge_chk.sv
module pa_host_bridge_chk
  import pa_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_cs_n,
  input logic              host_rd_wr,
  input logic              host_data_oe,
  input logic              cs_s,
  input logic              rw_s,
  input logic              acc_evt,
  input logic              rd_pend,
  input logic              rd_valid,
  input logic              first_acc,
  input logic              autoinc_en,
  input logic [ADDR_W-1:0] last_addr
);
  // R1, R4: the drive enable needs the select low two clocks earlier
  p_oe_needs_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_oe |-> !$past(host_cs_n, 2));

  // R4, R5: the drive enable is never high for a write
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_oe |-> $past(host_rd_wr, 2));

  // R3: a read event leads to pending, then to valid data
  p_read_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && rw_s) |=> rd_pend);
  p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !cs_s && !acc_evt) |=> rd_valid);

  // R1: an inactive select drops valid read data
  p_cs_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !rd_valid);

  // R7, R8: later accesses in a window step the address by one, modulo 4096
  p_autoinc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && autoinc_en && !first_acc) |=> last_addr == $past(last_addr) + ADDR_W'(1));
endmodule

bind pa_host_bridge pa_host_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_cs_n(host_cs_n), .host_rd_wr(host_rd_wr), .host_data_oe(host_data_oe),
  .cs_s(cs_s), .rw_s(rw_s), .acc_evt(acc_evt), .rd_pend(rd_pend),
  .rd_valid(rd_valid), .first_acc(first_acc), .autoinc_en(autoinc_en),
  .last_addr(last_addr)
);

// File: tb/tb_pa_host_bridge.sv
module tb_pa_host_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cs_n = 1'b1;
  logic host_strobe = 1'b0;
  logic host_rd_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_data_in = '0;
  logic [15:0] host_data_out;
  logic host_data_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pa_host_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_strobe(host_strobe),
    .host_rd_wr(host_rd_wr), .host_addr(host_addr), .host_data_in(host_data_in),
    .host_data_out(host_data_out), .host_data_oe(host_data_oe)
  );

  // {read, addr, data, expected}; autoinc off throughout
  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'h001, 16'hA5A5, 16'h0000},
    {1'b0, 12'h008, 16'h1234, 16'h0000},
    {1'b0, 12'h004, 16'hFFFF, 16'h0000},
    {1'b1, 12'h001, 16'h0000, 16'hA5A5},
    {1'b1, 12'h008, 16'h0000, 16'h1234},
    {1'b1, 12'h004, 16'h0000, 16'hFFFF},
    {1'b1, 12'h002, 16'h0000, 16'h0000},
    {1'b0, 12'h009, 16'hBEEF, 16'h0000},
    {1'b1, 12'h009, 16'h0000, 16'h0000},
    {1'b0, 12'h004, 16'h0F0F, 16'h0000},
    {1'b1, 12'h004, 16'h0000, 16'h0F0F},
    {1'b1, 12'h000, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk); host_cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_end();
    @(negedge clk); host_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe(input logic rw, input logic [11:0] a, input logic [15:0] d,
                        output logic [15:0] q, output logic oe);
    @(negedge clk);
    host_rd_wr = rw; host_addr = a; host_data_in = d;
    repeat (2) @(negedge clk);
    host_strobe = 1'b1;
    repeat (6) @(negedge clk);
    q = host_data_out; oe = host_data_oe;
    host_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic one_access(input logic rw, input logic [11:0] a, input logic [15:0] d,
                            output logic [15:0] q, output logic oe);
    cs_begin();
    strobe(rw, a, d, q, oe);
    cs_end();
  endtask

  initial begin
    logic [15:0] q;
    logic oe;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6, R11: reset state
    check("R4 oe low after reset", {15'b0, host_data_oe}, 16'h0000);
    one_access(1'b1, 12'h000, 16'h0, q, oe);
    check("R6 setup resets to 0", q, 16'h0000);
    one_access(1'b1, 12'h003, 16'h0, q, oe);
    check("R11 general reg resets to 0", q, 16'h0000);

    // R2, R3, R5, R9, R10: vector table
    for (int i = 0; i < NV; i++) begin
      one_access(VEC[i][44], VEC[i][43:32], VEC[i][31:16], q, oe);
      if (VEC[i][44]) begin
        check("R3 read data", q, VEC[i][15:0]);
        check("R4 oe high on read", {15'b0, oe}, 16'h0001);
      end else begin
        check("R5 oe low on write", {15'b0, oe}, 16'h0000);
      end
    end

    // R1: strobe with select high is ignored
    strobe(1'b0, 12'h001, 16'hDEAD, q, oe);
    strobe(1'b1, 12'h001, 16'h0, q, oe);
    check("R1 oe low with select high", {15'b0, oe}, 16'h0000);
    one_access(1'b1, 12'h001, 16'h0, q, oe);
    check("R1 reg unchanged by deselected write", q, 16'hA5A5);

    // R10: several strobes in one window, each uses bus address
    cs_begin();
    strobe(1'b0, 12'h002, 16'h2222, q, oe);
    strobe(1'b0, 12'h005, 16'h5555, q, oe);
    strobe(1'b1, 12'h002, 16'h0, q, oe);
    check("R10 bus address used (2)", q, 16'h2222);
    strobe(1'b1, 12'h005, 16'h0, q, oe);
    check("R10 bus address used (5)", q, 16'h5555);
    cs_end();

    // R6: enable auto-increment, upper bits read zero
    one_access(1'b0, 12'h000, 16'hFFFF, q, oe);
    one_access(1'b1, 12'h000, 16'h0, q, oe);
    check("R6 setup bit0 only", q, 16'h0001);

    // R7: write burst from 0x006; bus address ignored after first
    cs_begin();
    strobe(1'b0, 12'h006, 16'h6666, q, oe);
    strobe(1'b0, 12'h001, 16'h7777, q, oe);
    strobe(1'b0, 12'h001, 16'h8888, q, oe);
    cs_end();
    // R7: read burst from 0x006 returns the three values
    cs_begin();
    strobe(1'b1, 12'h006, 16'h0, q, oe);
    check("R7 burst read 6", q, 16'h6666);
    strobe(1'b1, 12'h001, 16'h0, q, oe);
    check("R7 burst read 7", q, 16'h7777);
    strobe(1'b1, 12'h001, 16'h0, q, oe);
    check("R7 burst read 8", q, 16'h8888);
    strobe(1'b1, 12'h001, 16'h0, q, oe);
    check("R9 burst read 9 unmapped", q, 16'h0000);
    cs_end();
    one_access(1'b1, 12'h001, 16'h0, q, oe);
    check("R7 reg 1 untouched by burst", q, 16'hA5A5);

    // R8: wrap 0xFFF -> 0x000, writing 0 disables auto-increment
    cs_begin();
    strobe(1'b0, 12'hFFF, 16'h1111, q, oe);
    strobe(1'b0, 12'h005, 16'h0000, q, oe);
    cs_end();
    one_access(1'b1, 12'h000, 16'h0, q, oe);
    check("R8 wrap reached setup reg", q, 16'h0000);
    one_access(1'b1, 12'h005, 16'h0, q, oe);
    check("R8 reg 5 not written on wrap", q, 16'h5555);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule